// File: doc/BRIEF.md
# Clock Domain Sleep Sequencer

This block keeps the power state of one clock domain shared by several slave modules. The domain has three states: off, running, and draining toward sleep. A wakeup request brings the domain out of off. A sleep request, once running, starts a drain. During the drain the member modules are asked to go idle, and the domain waits until they have done so.

If the wakeup returns or the sleep request is withdrawn during the drain, the domain goes back to running. It turns off only when three things hold together: every member reports that its clocks may be gated, no member still needs either shared clock, and both shared clock enables have already dropped.

The block drives one shared interface clock enable and one shared functional clock enable. Each enable is registered. While the domain is not off, each enable follows the OR of the members' need flags for that clock. The encoded domain state is broadcast to the per-module idle controllers.

Top module: `clkdom_seq`

## Requirements
- R1: After reset, dom_state_o is 2'b00 (off), and ick_en_o and fck_en_o are both 0.
- R2: In off (00), wake_i high moves dom_state_o to running (2'b01) on the next clock. With wake_i low the domain stays off, whatever the other inputs are.
- R3: In running (01), sleep_i high with wake_i low moves the domain to draining (2'b10) on the next clock. Any other input combination keeps it running.
- R4: In draining (10), wake_i high or sleep_i low returns the domain to running (01) on the next clock. This holds even when every sleep condition is met in the same cycle.
- R5: In draining, with sleep_i high and wake_i low, the domain goes off (00) on the next clock only if all of these hold: every bit of gate_ok_i is 1, need_ick_i and need_fck_i are all zero, and ick_en_o and fck_en_o are both 0. Otherwise it stays draining.
- R6: ick_en_o equals, one clock later, the value of (dom_state_o != 00) AND (OR of need_ick_i).
- R7: fck_en_o equals, one clock later, the value of (dom_state_o != 00) AND (OR of need_fck_i).
- R8: dom_state_o never takes the unused code 2'b11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wake_i | input | 1 | Domain wakeup request |
| sleep_i | input | 1 | Domain sleep request |
| gate_ok_i | input | N_MOD | Per-module flag: clocks may be gated |
| need_ick_i | input | N_MOD | Per-module need for the interface clock |
| need_fck_i | input | N_MOD | Per-module need for the functional clock |
| dom_state_o | output | 2 | Domain state: 00 off, 01 running, 10 draining |
| ick_en_o | output | 1 | Shared interface clock enable |
| fck_en_o | output | 1 | Shared functional clock enable |

## Verification
Every result appears exactly one clock after the inputs that cause it: the state transition and both enables. The drain-to-off path therefore needs at least two cycles after the need flags clear, because the enables drop one cycle before the state can move.

The bench drives inputs on the falling edge. At the next falling edge it compares all three outputs against a model that advances one step per cycle from the previous inputs. The long pseudo-random sweep is biased so that aborts, completed sleeps and wakeup-priority collisions each occur many times.

// File: rtl/clkdom_pkg.sv
package clkdom_pkg;
  typedef enum logic [1:0] {
    ST_OFF   = 2'b00,
    ST_ON    = 2'b01,
    ST_DRAIN = 2'b10
  } dom_st_e;

  localparam int unsigned N_CLK = 2;  // 0: interface, 1: functional
endpackage

// File: rtl/clkdom_gate.sv
module clkdom_gate #(
  parameter int unsigned N_MOD = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dom_on_i,
  input  logic [N_MOD-1:0] need_i,
  output logic             en_o
);
  logic en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= dom_on_i & (|need_i);
  end

  assign en_o = en_q;

  AST_GATED_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dom_on_i |=> !en_q); // R6
  AST_ON_WHEN_NEEDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dom_on_i && (|need_i)) |=> en_q); // R6
  AST_GATED_UNUSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|need_i) |=> !en_q); // R7
endmodule

// File: rtl/clkdom_fsm.sv
module clkdom_fsm
  import clkdom_pkg::*;
#(
  parameter int unsigned N_MOD = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wake_i,
  input  logic             sleep_i,
  input  logic [N_MOD-1:0] gate_ok_i,
  input  logic [N_MOD-1:0] need_ick_i,
  input  logic [N_MOD-1:0] need_fck_i,
  input  logic             ick_en_i,
  input  logic             fck_en_i,
  output dom_st_e          state_o
);
  dom_st_e state_q, state_d;
  logic    sleep_ok;

  // off only once members released and shared enables already low
  assign sleep_ok = (&gate_ok_i) & ~(|need_ick_i) & ~(|need_fck_i)
                  & ~ick_en_i & ~fck_en_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_OFF:   if (wake_i) state_d = ST_ON;
      ST_ON:    if (sleep_i && !wake_i) state_d = ST_DRAIN;
      ST_DRAIN: begin
        if (wake_i || !sleep_i) state_d = ST_ON;   // abort wins
        else if (sleep_ok)      state_d = ST_OFF;
      end
      default:  state_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_OFF;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  AST_WAKE_FROM_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_OFF && wake_i) |=> state_q == ST_ON); // R2
  AST_OFF_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_OFF && !wake_i) |=> state_q == ST_OFF); // R2
  AST_DRAIN_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ON && sleep_i && !wake_i) |=> state_q == ST_DRAIN); // R3
  AST_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DRAIN && (wake_i || !sleep_i)) |=> state_q == ST_ON); // R4
  AST_NO_EARLY_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DRAIN && (ick_en_i || fck_en_i)) |=> state_q != ST_OFF); // R5
  AST_LEGAL_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != 2'b11); // R8
endmodule

// File: rtl/clkdom_seq.sv
module clkdom_seq
  import clkdom_pkg::*;
#(
  parameter int unsigned N_MOD = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wake_i,
  input  logic             sleep_i,
  input  logic [N_MOD-1:0] gate_ok_i,
  input  logic [N_MOD-1:0] need_ick_i,
  input  logic [N_MOD-1:0] need_fck_i,
  output logic [1:0]       dom_state_o,
  output logic             ick_en_o,
  output logic             fck_en_o
);
  dom_st_e                       state;
  logic [N_CLK-1:0][N_MOD-1:0]   need_all;
  logic [N_CLK-1:0]              en_all;
  logic                          dom_on;

  assign need_all = {need_fck_i, need_ick_i};
  assign dom_on   = (state != ST_OFF);

  for (genvar g = 0; g < N_CLK; g++) begin : g_gate
    clkdom_gate #(.N_MOD(N_MOD)) u_gate (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .dom_on_i (dom_on),
      .need_i   (need_all[g]),
      .en_o     (en_all[g])
    );
  end

  clkdom_fsm #(.N_MOD(N_MOD)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wake_i     (wake_i),
    .sleep_i    (sleep_i),
    .gate_ok_i  (gate_ok_i),
    .need_ick_i (need_ick_i),
    .need_fck_i (need_fck_i),
    .ick_en_i   (en_all[0]),
    .fck_en_i   (en_all[1]),
    .state_o    (state)
  );

  assign dom_state_o = state;
  assign ick_en_o    = en_all[0];
  assign fck_en_o    = en_all[1];

  AST_OFF_CLOCKS_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_DRAIN && $past(state) == ST_DRAIN && !ick_en_o && !fck_en_o
     && sleep_i && !wake_i && (&gate_ok_i) && !(|need_ick_i) && !(|need_fck_i))
    |=> (dom_state_o == 2'b00 && !ick_en_o && !fck_en_o)); // R5
endmodule

// File: tb/clkdom_seq_tb.sv
module clkdom_seq_tb;
  localparam int unsigned N_MOD      = 3;
  localparam time         CLK_PERIOD = 10ns;
  localparam int          N_STEPS    = 20000;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             wake_i = 1'b0, sleep_i = 1'b0;
  logic [N_MOD-1:0] gate_ok_i = '0, need_ick_i = '0, need_fck_i = '0;
  logic [1:0]       dom_state_o;
  logic             ick_en_o, fck_en_o;

  int n_tests = 0, n_fail = 0;
  int n_off = 0, n_abort = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clkdom_seq #(.N_MOD(N_MOD)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .wake_i(wake_i), .sleep_i(sleep_i),
    .gate_ok_i(gate_ok_i), .need_ick_i(need_ick_i), .need_fck_i(need_fck_i),
    .dom_state_o(dom_state_o), .ick_en_o(ick_en_o), .fck_en_o(fck_en_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [1:0] m_st;
    logic       m_ick, m_fck;
    logic [1:0] n_st;
    logic [31:0] lfsr;
    string      sreq;

    @(negedge clk);
    check("R1 state", dom_state_o, 0);
    check("R1 ick", ick_en_o, 0);
    check("R1 fck", fck_en_o, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R2 stays off", dom_state_o, 0);

    m_st = 2'b00; m_ick = 1'b0; m_fck = 1'b0;
    lfsr = 32'hACE1_1234;
    for (int k = 0; k < N_STEPS; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      wake_i     = (lfsr[4:0] < 5'd4);
      sleep_i    = (lfsr[7:5] != 3'd0);
      gate_ok_i  = (lfsr[9:8] != 2'd0) ? '1 : lfsr[12:10];
      need_ick_i = (lfsr[15:13] > 3'd1) ? '0 : lfsr[18:16];
      need_fck_i = (lfsr[21:19] > 3'd1) ? '0 : lfsr[24:22];

      // reference step
      n_st = m_st;
      sreq = "R2";
      case (m_st)
        2'b00: if (wake_i) n_st = 2'b01;
        2'b01: begin sreq = "R3"; if (sleep_i && !wake_i) n_st = 2'b10; end
        2'b10: begin
          if (wake_i || !sleep_i) begin sreq = "R4"; n_st = 2'b01; n_abort++; end
          else begin
            sreq = "R5";
            if ((&gate_ok_i) && need_ick_i == '0 && need_fck_i == '0 && !m_ick && !m_fck) begin
              n_st = 2'b00; n_off++;
            end
          end
        end
        default: n_st = 2'b00;
      endcase
      m_ick = (m_st != 2'b00) && (|need_ick_i);
      m_fck = (m_st != 2'b00) && (|need_fck_i);
      m_st  = n_st;

      @(negedge clk);
      check(sreq, dom_state_o, m_st);
      check("R6", ick_en_o, m_ick);
      check("R7", fck_en_o, m_fck);
      check("R8", (dom_state_o == 2'b11), 0);
    end

    // coverage sanity: sweep must have reached off and aborted
    check("R5 off reached", (n_off > 10), 1);
    check("R4 aborts seen", (n_abort > 10), 1);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule